// File: doc/BRIEF.md
# Interrupt Pin Sampler

The block watches a bank of interrupt input pins and turns their activity into interrupt messages. Each pin owns a routing entry, supplied from outside, that gives its polarity, trigger mode (edge or level), mask bit, vector, destination, destination mode and delivery mode. The block keeps one request bit per pin, decides for each pin whether a message is owed, picks one pin at a time, and presents that pin's message on a valid/ready output. Level-triggered pins are held back by a per-pin remote-pending flag. The flag is raised when their message is accepted, and it is lowered by a table write pulse for that entry.

Any assertion that cannot be turned into a new message is reported on a per-pin coalesced pulse. An edge pin can hit this because an earlier event is still waiting. A level pin can hit it because its remote-pending flag is set. A controller upstream decodes the routing table and drives the entry inputs. The end-of-interrupt handler downstream uses the write pulse to release remote-pending flags.

The control is a two-state machine. In state `ST_IDLE`, the transition *pick* is taken when any pin needs service: the lowest-index pin is latched and the machine enters `ST_SEND`. In `ST_SEND`, the transition *accept* is taken when the message is accepted (`msg_ready` high), and the machine returns to `ST_IDLE`. While `msg_ready` is low, the machine stays in `ST_SEND` (*hold*). When no pin needs service, it stays in `ST_IDLE` (*wait*).

Top module: `irq_pin_sampler`

## Requirements
- R1: The effective level of pin i is `pin_in[i]` XOR `cfg_pol[i]`. The input is registered once, and the request bit follows the registered effective level one cycle later.
- R2: An edge pin (`cfg_level[i]`=0) owes one message per 0→1 change of its request bit. A level held high produces no further message. With `msg_ready` low and no other activity, `msg_valid` rises on the third clock edge after the pin change.
- R3: A level pin (`cfg_level[i]`=1) owes a message while its request bit is high and its remote-pending flag is clear. Acceptance of that message sets `remote_pend[i]`.
- R4: A level pin whose remote-pending flag is set sends nothing more. A 0→1 change of its request bit while the flag is set gives a one-cycle pulse on `coal[i]`.
- R5: An edge pin whose earlier event has not yet been accepted does not queue a second one. A new rise in that state gives a one-cycle pulse on `coal[i]`, and in total exactly one message goes out.
- R6: A masked entry (`cfg_mask[i]`=1) sends nothing, and an edge rise seen while masked is discarded. A level pin whose request is still high sends its message once unmasked.
- R7: A message carries the chosen entry's vector, destination, destination mode, delivery mode, and its trigger mode on `msg_level` (1 = level).
- R8: Once `msg_valid` is high, it stays high with stable fields until the cycle `msg_ready` is high. That cycle is the delivery, and `msg_valid` is low in the next cycle.
- R9: When several pins owe messages, the lowest pin index goes first. The others wait for later cycles.
- R10: A pulse on `cfg_wr[i]` clears `remote_pend[i]`. A level entry whose request bit is still high is then serviced again.
- R11: After reset, `msg_valid`, `coal` and `remote_pend` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPINS | Raw interrupt pins |
| cfg_pol | input | NPINS | Per-pin polarity invert |
| cfg_level | input | NPINS | Per-pin trigger mode, 1 = level |
| cfg_mask | input | NPINS | Per-pin mask |
| cfg_dmode | input | NPINS | Per-pin destination mode |
| cfg_deliv | input | NPINS*DLV_W | Per-pin delivery mode, pin i at bits [i*DLV_W +: DLV_W] |
| cfg_vector | input | NPINS*VEC_W | Per-pin vector, pin i at bits [i*VEC_W +: VEC_W] |
| cfg_dest | input | NPINS*DEST_W | Per-pin destination, pin i at bits [i*DEST_W +: DEST_W] |
| cfg_wr | input | NPINS | Table write pulse per entry |
| msg_ready | input | 1 | Message sink ready |
| msg_valid | output | 1 | Message valid |
| msg_vector | output | VEC_W | Message vector |
| msg_dest | output | DEST_W | Message destination |
| msg_dmode | output | 1 | Message destination mode |
| msg_deliv | output | DLV_W | Message delivery mode |
| msg_level | output | 1 | Message trigger mode |
| coal | output | NPINS | Coalesced-assertion pulses |
| remote_pend | output | NPINS | Remote-pending flags |

## Verification
A pin change takes three clock edges to reach `msg_valid`: the input register, the request register and the pick into `ST_SEND`. A coalesced pulse appears after the second edge. The bench drives inputs just after a rising edge and reads outputs at the falling edge, so it counts falling edges from the drive to those positions. The random phase does not depend on exact cycles. For every edge pin it checks that messages plus coalesced pulses equal the number of effective rises, after a drain with `msg_ready` held high.

// File: rtl/irq_sampler_pkg.sv
package irq_sampler_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } samp_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_pin_front.sv
module irq_pin_front #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] cfg_pol,
    input  logic [NPINS-1:0] cfg_level,
    input  logic [NPINS-1:0] cfg_mask,
    input  logic [NPINS-1:0] cfg_wr,
    input  logic [NPINS-1:0] done,
    output logic [NPINS-1:0] need,
    output logic [NPINS-1:0] remote_pend,
    output logic [NPINS-1:0] coal
);

    logic [NPINS-1:0] pin_s;
    logic [NPINS-1:0] req_q;
    logic [NPINS-1:0] edge_pend;
    logic [NPINS-1:0] remote_q;
    logic [NPINS-1:0] coal_q;
    logic [NPINS-1:0] eff;
    logic [NPINS-1:0] rise;

    assign eff  = pin_s ^ cfg_pol;
    assign rise = eff & ~req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_s <= '0;
            req_q <= '0;
        end else begin
            pin_s <= pin_in;
            req_q <= eff;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_pend <= '0;
            remote_q  <= '0;
            coal_q    <= '0;
        end else begin
            for (int i = 0; i < NPINS; i++) begin
                // edge events: masked or level entries hold none
                if (cfg_level[i] || cfg_mask[i])
                    edge_pend[i] <= 1'b0;
                else if (rise[i])
                    edge_pend[i] <= 1'b1;
                else if (done[i])
                    edge_pend[i] <= 1'b0;
                // remote-pending: write clears, level delivery sets
                if (cfg_wr[i])
                    remote_q[i] <= 1'b0;
                else if (done[i] && cfg_level[i])
                    remote_q[i] <= 1'b1;
                coal_q[i] <= rise[i] &
                    ((~cfg_level[i] & ~cfg_mask[i] & edge_pend[i] & ~done[i]) |
                     (cfg_level[i] & remote_q[i]));
            end
        end
    end

    assign need        = (edge_pend | (cfg_level & req_q & ~remote_q)) & ~cfg_mask;
    assign remote_pend = remote_q;
    assign coal        = coal_q;

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NPINS = 8,
    parameter int IDX_W = 3
) (
    input  logic [NPINS-1:0] need,
    output logic             any,
    output logic [IDX_W-1:0] pick
);

    logic [NPINS:0]   lower_any;
    logic [NPINS-1:0] grant;

    assign lower_any[0] = 1'b0;

    for (genvar g = 0; g < NPINS; g++) begin : g_chain
        assign grant[g]       = need[g] & ~lower_any[g];
        assign lower_any[g+1] = lower_any[g] | need[g];
    end

    always_comb begin
        pick = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (grant[i])
                pick = pick | IDX_W'(i);
        end
    end

    assign any = lower_any[NPINS];

endmodule

// File: rtl/irq_pin_sampler.sv
module irq_pin_sampler
    import irq_sampler_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int VEC_W  = 8,
    parameter int DEST_W = 8,
    parameter int DLV_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPINS-1:0]        pin_in,
    input  logic [NPINS-1:0]        cfg_pol,
    input  logic [NPINS-1:0]        cfg_level,
    input  logic [NPINS-1:0]        cfg_mask,
    input  logic [NPINS-1:0]        cfg_dmode,
    input  logic [NPINS*DLV_W-1:0]  cfg_deliv,
    input  logic [NPINS*VEC_W-1:0]  cfg_vector,
    input  logic [NPINS*DEST_W-1:0] cfg_dest,
    input  logic [NPINS-1:0]        cfg_wr,
    input  logic                    msg_ready,
    output logic                    msg_valid,
    output logic [VEC_W-1:0]        msg_vector,
    output logic [DEST_W-1:0]       msg_dest,
    output logic                    msg_dmode,
    output logic [DLV_W-1:0]        msg_deliv,
    output logic                    msg_level,
    output logic [NPINS-1:0]        coal,
    output logic [NPINS-1:0]        remote_pend
);

    localparam int IDX_W = idx_width(NPINS);

    samp_state_e      state_q, state_d;
    logic [NPINS-1:0] need;
    logic [NPINS-1:0] done;
    logic             any_need;
    logic [IDX_W-1:0] pick;
    logic [IDX_W-1:0] idx_q;
    logic             take;

    irq_pin_front #(.NPINS(NPINS)) front_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_in      (pin_in),
        .cfg_pol     (cfg_pol),
        .cfg_level   (cfg_level),
        .cfg_mask    (cfg_mask),
        .cfg_wr      (cfg_wr),
        .done        (done),
        .need        (need),
        .remote_pend (remote_pend),
        .coal        (coal)
    );

    irq_prio_pick #(.NPINS(NPINS), .IDX_W(IDX_W)) pick_i (
        .need (need),
        .any  (any_need),
        .pick (pick)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // transitions: wait / pick / hold / accept
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any_need)  state_d = ST_SEND;
            ST_SEND: if (msg_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign take = (state_q == ST_IDLE) && any_need;

    // message latch on pick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            msg_vector <= '0;
            msg_dest   <= '0;
            msg_dmode  <= 1'b0;
            msg_deliv  <= '0;
            msg_level  <= 1'b0;
        end else if (take) begin
            idx_q      <= pick;
            msg_vector <= cfg_vector[int'(pick)*VEC_W +: VEC_W];
            msg_dest   <= cfg_dest[int'(pick)*DEST_W +: DEST_W];
            msg_dmode  <= cfg_dmode[pick];
            msg_deliv  <= cfg_deliv[int'(pick)*DLV_W +: DLV_W];
            msg_level  <= cfg_level[pick];
        end
    end

    // outputs of the state machine
    always_comb begin
        msg_valid = 1'b0;
        done      = '0;
        unique case (state_q)
            ST_IDLE: msg_valid = 1'b0;
            ST_SEND: begin
                msg_valid = 1'b1;
                if (msg_ready)
                    done = NPINS'(1) << idx_q;
            end
            default: msg_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_pin_sampler_chk.sv
module irq_pin_sampler_chk #(
    parameter int NPINS  = 8,
    parameter int VEC_W  = 8,
    parameter int DEST_W = 8,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic              msg_level,
    input logic [VEC_W-1:0]  msg_vector,
    input logic [DEST_W-1:0] msg_dest,
    input logic [NPINS-1:0]  cfg_mask,
    input logic [NPINS-1:0]  cfg_level,
    input logic [NPINS-1:0]  cfg_wr,
    input logic [NPINS-1:0]  remote_pend,
    input logic [IDX_W-1:0]  sel_idx
);

    logic [NPINS-1:0] mask_d;
    logic [NPINS-1:0] remote_d;

    always_ff @(posedge clk) begin
        mask_d   <= cfg_mask;
        remote_d <= remote_pend;
    end

    // R8
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dest));

    // R6
    no_masked_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> !mask_d[sel_idx]);

    // R4
    remote_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) && msg_level |-> !remote_d[sel_idx]);

    // R3
    remote_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_ready && cfg_level[sel_idx] && !cfg_wr[sel_idx] |=> remote_pend[sel_idx]);

endmodule

bind irq_pin_sampler irq_pin_sampler_chk #(
    .NPINS  (NPINS),
    .VEC_W  (VEC_W),
    .DEST_W (DEST_W),
    .IDX_W  (IDX_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .msg_valid   (msg_valid),
    .msg_ready   (msg_ready),
    .msg_level   (msg_level),
    .msg_vector  (msg_vector),
    .msg_dest    (msg_dest),
    .cfg_mask    (cfg_mask),
    .cfg_level   (cfg_level),
    .cfg_wr      (cfg_wr),
    .remote_pend (remote_pend),
    .sel_idx     (idx_q)
);

// File: tb/irq_pin_sampler_tb_top.sv
module irq_pin_sampler_tb_top;

    localparam int NPINS  = 8;
    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;
    localparam int DLV_W  = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                    rst_n;
    logic [NPINS-1:0]        pin_in, cfg_pol, cfg_level, cfg_mask, cfg_dmode, cfg_wr;
    logic [NPINS*DLV_W-1:0]  cfg_deliv;
    logic [NPINS*VEC_W-1:0]  cfg_vector;
    logic [NPINS*DEST_W-1:0] cfg_dest;
    logic                    msg_ready, msg_valid, msg_dmode, msg_level;
    logic [VEC_W-1:0]        msg_vector;
    logic [DEST_W-1:0]       msg_dest;
    logic [DLV_W-1:0]        msg_deliv;
    logic [NPINS-1:0]        coal, remote_pend;

    irq_pin_sampler #(.NPINS(NPINS), .VEC_W(VEC_W), .DEST_W(DEST_W), .DLV_W(DLV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_pol(cfg_pol),
        .cfg_level(cfg_level), .cfg_mask(cfg_mask), .cfg_dmode(cfg_dmode),
        .cfg_deliv(cfg_deliv), .cfg_vector(cfg_vector), .cfg_dest(cfg_dest),
        .cfg_wr(cfg_wr), .msg_ready(msg_ready), .msg_valid(msg_valid),
        .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_dmode(msg_dmode),
        .msg_deliv(msg_deliv), .msg_level(msg_level), .coal(coal),
        .remote_pend(remote_pend)
    );

    int checks = 0;
    int errors = 0;
    int msg_pin [NPINS];
    int coal_cnt[NPINS];
    int rises   [NPINS];
    int base_msg[NPINS];
    int base_coal[NPINS];

    function automatic logic [VEC_W-1:0]  exp_vec (int i); return VEC_W'(8'h40 + i * 3); endfunction
    function automatic logic [DEST_W-1:0] exp_dest(int i); return DEST_W'(8'h90 ^ i);    endfunction
    function automatic logic [DLV_W-1:0]  exp_dlv (int i); return DLV_W'(i % 5);         endfunction
    function automatic logic              exp_dm  (int i); return i[0];                  endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive_edge();
        @(posedge clk);
        #2;
    endtask

    task automatic cyc(input int n);
        repeat (n) drive_edge();
    endtask

    // monitor at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (msg_valid && msg_ready) begin
                for (int i = 0; i < NPINS; i++)
                    if (msg_vector == exp_vec(i)) msg_pin[i]++;
            end
            for (int i = 0; i < NPINS; i++)
                if (coal[i]) coal_cnt[i]++;
        end
    end

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NPINS; i++) begin
            msg_pin[i] = 0; coal_cnt[i] = 0; rises[i] = 0;
            cfg_vector[i*VEC_W +: VEC_W]   = exp_vec(i);
            cfg_dest[i*DEST_W +: DEST_W]   = exp_dest(i);
            cfg_deliv[i*DLV_W +: DLV_W]    = exp_dlv(i);
            cfg_dmode[i]                   = exp_dm(i);
        end
        rst_n = 1'b0; pin_in = '0; cfg_pol = '0; cfg_level = '0;
        cfg_mask = '1; cfg_wr = '0; msg_ready = 1'b0;
        cyc(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(msg_valid == 1'b0, "R11", "msg_valid", msg_valid, 0);
        chk(coal == '0, "R11", "coal", coal, 0);
        chk(remote_pend == '0, "R11", "remote_pend", remote_pend, 0);

        // R2 / R7 / R8: edge pin 2, exact latency and fields
        drive_edge();
        cfg_mask[2] = 1'b0;
        cyc(2);
        pin_in[2] = 1'b1;
        repeat (3) @(negedge clk);
        chk(msg_valid == 1'b0, "R2", "valid before third edge", msg_valid, 0);
        @(negedge clk);
        chk(msg_valid == 1'b1, "R2", "valid at third edge", msg_valid, 1);
        chk(msg_vector == exp_vec(2), "R7", "vector", msg_vector, exp_vec(2));
        chk(msg_dest == exp_dest(2), "R7", "dest", msg_dest, exp_dest(2));
        chk(msg_dmode == exp_dm(2), "R7", "dmode", msg_dmode, exp_dm(2));
        chk(msg_deliv == exp_dlv(2), "R7", "deliv", msg_deliv, exp_dlv(2));
        chk(msg_level == 1'b0, "R7", "trigger mode", msg_level, 0);
        repeat (4) @(negedge clk);
        chk(msg_valid && msg_vector == exp_vec(2), "R8", "held while not ready", msg_vector, exp_vec(2));
        drive_edge();
        msg_ready = 1'b1;
        drive_edge();
        msg_ready = 1'b0;
        @(negedge clk);
        chk(msg_valid == 1'b0, "R8", "valid low after delivery", msg_valid, 0);
        cyc(8);
        @(negedge clk);
        chk(msg_valid == 1'b0 && msg_pin[2] == 1, "R2", "no repeat while held", msg_pin[2], 1);

        // R1 / R6: inverted pin 3, rise while masked discarded
        drive_edge();
        cfg_pol[3] = 1'b1;
        cyc(4);
        cfg_mask[3] = 1'b0;
        cyc(6);
        @(negedge clk);
        chk(msg_valid == 1'b0, "R6", "masked rise discarded", msg_valid, 0);
        drive_edge();
        pin_in[3] = 1'b1;
        cyc(3);
        pin_in[3] = 1'b0;
        repeat (4) @(negedge clk);
        chk(msg_valid && msg_vector == exp_vec(3), "R1", "inverted pin fires on low", msg_vector, exp_vec(3));
        drive_edge();
        msg_ready = 1'b1;
        cyc(2);

        // R9: pins 1 and 5 together
        msg_ready = 1'b0;
        cfg_mask[1] = 1'b0; cfg_mask[5] = 1'b0;
        cyc(2);
        pin_in[1] = 1'b1; pin_in[5] = 1'b1;
        repeat (4) @(negedge clk);
        chk(msg_valid && msg_vector == exp_vec(1), "R9", "lowest index first", msg_vector, exp_vec(1));
        drive_edge();
        msg_ready = 1'b1;
        cyc(6);
        chk(msg_pin[1] == 1 && msg_pin[5] == 1, "R9", "second pin served later", msg_pin[5], 1);

        // R5: edge pin 6 re-asserts while waiting
        msg_ready = 1'b0;
        cfg_mask[6] = 1'b0;
        cyc(2);
        pin_in[6] = 1'b1;
        cyc(4);
        pin_in[6] = 1'b0;
        cyc(2);
        pin_in[6] = 1'b1;
        cyc(4);
        chk(coal_cnt[6] == 1, "R5", "coalesced pulse", coal_cnt[6], 1);
        msg_ready = 1'b1;
        cyc(8);
        chk(msg_pin[6] == 1, "R5", "single message", msg_pin[6], 1);

        // R3 / R4: level pin 4
        cfg_level[4] = 1'b1; cfg_mask[4] = 1'b0;
        cyc(2);
        pin_in[4] = 1'b1;
        cyc(8);
        chk(msg_pin[4] == 1, "R3", "level delivered", msg_pin[4], 1);
        chk(remote_pend[4] == 1'b1, "R3", "remote set", remote_pend[4], 1);
        cyc(10);
        chk(msg_pin[4] == 1, "R4", "no resend while remote", msg_pin[4], 1);
        pin_in[4] = 1'b0;
        cyc(3);
        pin_in[4] = 1'b1;
        cyc(5);
        chk(coal_cnt[4] == 1 && msg_pin[4] == 1, "R4", "coalesced level", coal_cnt[4], 1);

        // R10: table write re-services
        msg_ready = 1'b0;
        cfg_wr[4] = 1'b1;
        drive_edge();
        cfg_wr[4] = 1'b0;
        cyc(2);
        @(negedge clk);
        chk(remote_pend[4] == 1'b0, "R10", "remote cleared", remote_pend[4], 0);
        chk(msg_valid && msg_vector == exp_vec(4), "R10", "re-serviced", msg_vector, exp_vec(4));
        drive_edge();
        msg_ready = 1'b1;
        cyc(4);
        chk(msg_pin[4] == 2 && remote_pend[4], "R10", "second delivery", msg_pin[4], 2);

        // R6: masked level pin 7 then unmask
        cfg_level[7] = 1'b1;
        pin_in[7] = 1'b1;
        cyc(10);
        chk(msg_pin[7] == 0, "R6", "masked level silent", msg_pin[7], 0);
        cfg_mask[7] = 1'b0;
        cyc(6);
        chk(msg_pin[7] == 1, "R6", "unmask delivers", msg_pin[7], 1);

        // R2 / R5 random: all pins edge, unmasked
        cfg_level = '0; cfg_pol = '0; cfg_mask = '0; pin_in = '0;
        cyc(10);
        for (int i = 0; i < NPINS; i++) begin
            base_msg[i] = msg_pin[i]; base_coal[i] = coal_cnt[i];
        end
        for (int c = 0; c < 3000; c++) begin
            logic [NPINS-1:0] nxt;
            nxt = NPINS'($urandom);
            for (int i = 0; i < NPINS; i++)
                if (nxt[i] && !pin_in[i]) rises[i]++;
            pin_in = nxt;
            msg_ready = ($urandom % 3) != 0;
            drive_edge();
        end
        pin_in = '0;
        msg_ready = 1'b1;
        cyc(40);
        for (int i = 0; i < NPINS; i++)
            chk((msg_pin[i] - base_msg[i]) + (coal_cnt[i] - base_coal[i]) == rises[i],
                "R5", $sformatf("pin %0d messages+coalesced", i),
                (msg_pin[i] - base_msg[i]) + (coal_cnt[i] - base_coal[i]), rises[i]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule